// File: doc/BRIEF.md
# Parallel SECDED Memory EDAC Unit

This block guards a 16-bit memory data path with a 6-bit check word. On the write side, it computes the check bits for a data word so that both can be stored together. On the read side, it takes the 22-bit stored word and computes a 6-bit syndrome. It then classifies the result as clean, single-bit error or uncorrectable error. A single flipped data bit is repaired before the word is driven out. A single flipped check bit is reported but left as it is. The syndrome is always visible on an output, so software or a scrub engine can find the bad bit.

The code gives every data bit a distinct 6-bit column of weight three, and every check bit a column of weight one. Any single error therefore produces an odd-weight syndrome that names the bit. Any double error produces a nonzero even-weight syndrome. A two-bit mode input selects one of three operations: generate, detect only, or detect and correct. All outputs are registered and appear one clock after their inputs are sampled.

Top module: `edac_unit`

## Requirements
- R1: Mode 00 generates check bits. Data bit i is assigned the i-th smallest 6-bit value that has exactly three bits set (bit 0 gets 6'b000111, bit 15 gets 6'b101100). Check bit j is the XOR of every data bit whose assigned value has bit j set. The next cycle, chk_o holds this check word, data_o equals data_i, syn_o is zero and both flags are low, whatever chk_i holds.
- R2: In modes 01, 10 and 11, syn_o equals the check word computed from data_i (as in R1) XOR chk_i.
- R3: When that syndrome is zero, both flags are low and data_o equals data_i.
- R4: In modes 10 and 11, a syndrome equal to the value assigned to data bit i raises sgl_err_o, keeps dbl_err_o low, and drives data_o with bit i of data_i inverted.
- R5: A syndrome with exactly one bit j set raises sgl_err_o and keeps dbl_err_o low. The check bits are never corrected: chk_o equals chk_i in modes 01, 10 and 11, and data_o equals data_i.
- R6: Mode 01 reports flags and syndrome exactly as the correcting modes do, but data_o always equals data_i.
- R7: Any two flipped bits in the 22-bit word raise dbl_err_o, keep sgl_err_o low, and leave data_o equal to data_i.
- R8: A nonzero syndrome that matches no data-bit value and no check-bit value is reported as a double error, with data_o equal to data_i. This covers the four unused weight-three values and any syndrome of weight five or six.
- R9: Inputs are sampled on the rising clock edge, and the outputs change only at the next rising edge, one cycle of latency.
- R10: A synchronous active-high rst clears data_o, chk_o, syn_o and both flags on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 2 | 00 generate, 01 detect, 10/11 detect and correct |
| data_i | input | 16 | Data word from the writer or from memory |
| chk_i | input | 6 | Stored check word (read modes) |
| data_o | output | 16 | Registered data, corrected in modes 10/11 |
| chk_o | output | 6 | Registered check word: generated in mode 00, passed through otherwise |
| syn_o | output | 6 | Registered syndrome |
| sgl_err_o | output | 1 | Single-bit error detected |
| dbl_err_o | output | 1 | Uncorrectable error detected |

## Verification
The bench builds the unit at its default 16 data bits and 6 check bits. At that size, 16 of the 20 weight-three columns are used, so four weight-three syndromes name no bit. This makes the unmatched-syndrome rule reachable with a crafted three-bit flip, and the weight-five case reachable with a five-bit flip of the check field. Every first and last position of both fields is flipped, and mode 01 is exercised against the same error patterns as the correcting modes.

// File: rtl/edac_pkg.sv
package edac_pkg;

    typedef enum logic [1:0] {
        MODE_GEN  = 2'b00,
        MODE_DET  = 2'b01,
        MODE_COR  = 2'b10,
        MODE_COR2 = 2'b11
    } edac_mode_e;

    // Column assigned to data bit idx: idx-th smallest value of weight three.
    function automatic logic [31:0] col_code(input int idx, input int chk_w);
        int          seen;
        logic [31:0] res;
        seen = 0;
        res  = '0;
        for (int v = 0; v < (1 << chk_w); v++) begin
            if ($countones(32'(v)) == 3) begin
                if (seen == idx) res = 32'(v);
                seen++;
            end
        end
        return res;
    endfunction

    // Number of weight-three columns available for chk_w check bits.
    function automatic int col_capacity(input int chk_w);
        return (chk_w * (chk_w - 1) * (chk_w - 2)) / 6;
    endfunction

endpackage

// File: rtl/edac_encoder.sv
module edac_encoder #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o
);
    logic [CHK_W-1:0] col_w [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [31:0] COL = edac_pkg::col_code(i, CHK_W);
        assign col_w[i] = COL[CHK_W-1:0];
    end

    always_comb begin
        chk_o = '0;
        for (int j = 0; j < CHK_W; j++) begin
            for (int i = 0; i < DATA_W; i++) begin
                if (col_w[i][j]) chk_o[j] = chk_o[j] ^ data_i[i];
            end
        end
    end
endmodule

// File: rtl/edac_locator.sv
module edac_locator #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input  logic [CHK_W-1:0]  syn_i,
    output logic [DATA_W-1:0] data_hit_o,
    output logic [CHK_W-1:0]  chk_hit_o,
    output logic              single_o,
    output logic              double_o
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_dhit
        localparam logic [31:0] COL = edac_pkg::col_code(i, CHK_W);
        assign data_hit_o[i] = (syn_i == COL[CHK_W-1:0]);
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_chit
        assign chk_hit_o[j] = (syn_i == CHK_W'(1 << j));
    end

    logic nonzero;
    assign nonzero  = |syn_i;
    assign single_o = (|data_hit_o) | (|chk_hit_o);
    assign double_o = nonzero & ~single_o;
endmodule

// File: rtl/edac_corrector.sv
module edac_corrector #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] hit_i,
    input  logic              en_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] flip;
    assign flip   = en_i ? hit_i : '0;
    assign data_o = data_i ^ flip;
endmodule

// File: rtl/edac_unit.sv
module edac_unit #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  chk_o,
    output logic [CHK_W-1:0]  syn_o,
    output logic              sgl_err_o,
    output logic              dbl_err_o
);
    import edac_pkg::*;

    localparam int CAP = col_capacity(CHK_W);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic [CHK_W-1:0]  syn;
        logic              sgl;
        logic              dbl;
    } out_t;

    out_t out_d, out_q;

    edac_mode_e        mode;
    logic [CHK_W-1:0]  gen_chk;
    logic [CHK_W-1:0]  syn_raw;
    logic [DATA_W-1:0] data_hit;
    logic [CHK_W-1:0]  chk_hit;
    logic              is_single;
    logic              is_double;
    logic              fix_en;
    logic [DATA_W-1:0] fixed_data;

    assign mode = edac_mode_e'(mode_i);

    edac_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
        .data_i (data_i),
        .chk_o  (gen_chk)
    );

    assign syn_raw = gen_chk ^ chk_i;

    edac_locator #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_loc (
        .syn_i      (syn_raw),
        .data_hit_o (data_hit),
        .chk_hit_o  (chk_hit),
        .single_o   (is_single),
        .double_o   (is_double)
    );

    assign fix_en = (mode == MODE_COR) || (mode == MODE_COR2);

    edac_corrector #(.DATA_W(DATA_W)) u_fix (
        .data_i (data_i),
        .hit_i  (data_hit),
        .en_i   (fix_en),
        .data_o (fixed_data)
    );

    always_comb begin
        out_d = '0;
        unique case (mode)
            MODE_GEN: begin
                out_d.data = data_i;
                out_d.chk  = gen_chk;
            end
            MODE_DET: begin
                out_d.data = data_i;
                out_d.chk  = chk_i;
                out_d.syn  = syn_raw;
                out_d.sgl  = is_single;
                out_d.dbl  = is_double;
            end
            default: begin
                out_d.data = fixed_data;
                out_d.chk  = chk_i;
                out_d.syn  = syn_raw;
                out_d.sgl  = is_single;
                out_d.dbl  = is_double;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign data_o    = out_q.data;
    assign chk_o     = out_q.chk;
    assign syn_o     = out_q.syn;
    assign sgl_err_o = out_q.sgl;
    assign dbl_err_o = out_q.dbl;

    initial begin
        if (DATA_W > CAP) $error("DATA_W exceeds available weight-three columns");
    end
endmodule

// File: rtl/edac_unit_chk.sv
module edac_unit_chk #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] data_i,
    input logic [CHK_W-1:0]  chk_i,
    input logic [DATA_W-1:0] data_o,
    input logic [CHK_W-1:0]  chk_o,
    input logic [CHK_W-1:0]  syn_o,
    input logic              sgl_err_o,
    input logic              dbl_err_o
);
    AST_GEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b00 |=> (!sgl_err_o && !dbl_err_o && syn_o == '0
                             && data_o == $past(data_i))); // R1

    AST_ZERO_SYN_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        syn_o == '0 |-> (!sgl_err_o && !dbl_err_o)); // R3

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(sgl_err_o && dbl_err_o)); // R7

    AST_SINGLE_ODD_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        sgl_err_o |-> ($countones(syn_o) == 1 || $countones(syn_o) == 3)); // R4

    AST_CHK_NOT_FIXED: assert property (@(posedge clk) disable iff (rst)
        mode_i != 2'b00 |=> chk_o == $past(chk_i)); // R5

    AST_DETECT_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b01 |=> data_o == $past(data_i)); // R6

    AST_DOUBLE_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        mode_i[1] |=> (!dbl_err_o || data_o == $past(data_i))); // R7

    AST_NONZERO_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        syn_o != '0 |-> (sgl_err_o || dbl_err_o)); // R8
endmodule

bind edac_unit edac_unit_chk #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_i    (mode_i),
    .data_i    (data_i),
    .chk_i     (chk_i),
    .data_o    (data_o),
    .chk_o     (chk_o),
    .syn_o     (syn_o),
    .sgl_err_o (sgl_err_o),
    .dbl_err_o (dbl_err_o)
);

// File: tb/edac_unit_bench.sv
module edac_unit_bench;
    localparam int DW = 16;
    localparam int CW = 6;
    localparam int NV = 17;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] data;
        logic [21:0] flip;
        logic        sgl;
        logic        dbl;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'b00, 16'h1234, 22'h000000, 1'b0, 1'b0},
        '{2'b00, 16'hFFFF, 22'h000000, 1'b0, 1'b0},
        '{2'b01, 16'hA5A5, 22'h000000, 1'b0, 1'b0},
        '{2'b10, 16'h5A5A, 22'h000001, 1'b1, 1'b0},
        '{2'b11, 16'hBEEF, 22'h008000, 1'b1, 1'b0},
        '{2'b10, 16'h0000, 22'h010000, 1'b1, 1'b0},
        '{2'b10, 16'hFFFF, 22'h200000, 1'b1, 1'b0},
        '{2'b01, 16'hC3C3, 22'h000080, 1'b1, 1'b0},
        '{2'b10, 16'h1357, 22'h000204, 1'b0, 1'b1},
        '{2'b11, 16'h2468, 22'h020008, 1'b0, 1'b1},
        '{2'b10, 16'h0F0F, 22'h030000, 1'b0, 1'b1},
        '{2'b01, 16'h7777, 22'h000003, 1'b0, 1'b1},
        '{2'b00, 16'h8001, 22'h3F0000, 1'b0, 1'b0},
        '{2'b10, 16'h6B6B, 22'h360001, 1'b0, 1'b1},
        '{2'b11, 16'h9999, 22'h1F0000, 1'b0, 1'b1},
        '{2'b10, 16'hDEAD, 22'h000000, 1'b0, 1'b0},
        '{2'b11, 16'h0001, 22'h000001, 1'b1, 1'b0}
    };

    localparam string VREQ [NV] = '{
        "R1", "R1", "R2", "R4", "R4", "R5", "R5", "R6", "R7",
        "R7", "R7", "R6", "R1", "R8", "R8", "R3", "R4"
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_i = 2'b00;
    logic [DW-1:0] data_i = '0;
    logic [CW-1:0] chk_i = '0;
    logic [DW-1:0] data_o;
    logic [CW-1:0] chk_o;
    logic [CW-1:0] syn_o;
    logic          sgl_err_o;
    logic          dbl_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    edac_unit u_edac_unit (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .data_i    (data_i),
        .chk_i     (chk_i),
        .data_o    (data_o),
        .chk_o     (chk_o),
        .syn_o     (syn_o),
        .sgl_err_o (sgl_err_o),
        .dbl_err_o (dbl_err_o)
    );

    // Reference column: count upward, keep values with three ones.
    function automatic logic [5:0] ref_col(input int idx);
        int k = -1;
        logic [5:0] v = 6'd0;
        while (1) begin
            if ((v[0] + v[1] + v[2] + v[3] + v[4] + v[5]) == 3) k++;
            if (k == idx) return v;
            v = v + 6'd1;
        end
    endfunction

    function automatic logic [5:0] ref_gen(input logic [15:0] d);
        logic [5:0] c = 6'd0;
        for (int i = 0; i < 16; i++) if (d[i]) c = c ^ ref_col(i);
        return c;
    endfunction

    task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (data,chk,syn,sgl,dbl)", req, act, exp);
        end
    endtask

    function automatic logic [30:0] outs();
        return {data_o, chk_o, syn_o, sgl_err_o, dbl_err_o};
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [21:0] stored;
        logic [15:0] drx;
        logic [5:0]  crx;
        logic [5:0]  esyn;
        logic [15:0] edata;
        logic [5:0]  echk;

        // R10: reset state
        mode_i = 2'b10;
        data_i = 16'hFFFF;
        chk_i  = 6'h2A;
        repeat (2) @(posedge clk);
        #1;
        check("R10", outs(), 31'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int n = 0; n < NV; n++) begin
            stored = {ref_gen(VEC[n].data), VEC[n].data} ^ VEC[n].flip;
            drx = stored[15:0];
            crx = stored[21:16];
            mode_i = VEC[n].mode;
            data_i = drx;
            chk_i  = crx;
            if (VEC[n].mode == 2'b00) begin
                esyn  = 6'd0;
                echk  = ref_gen(drx);
                edata = drx;
            end else begin
                esyn  = ref_gen(drx) ^ crx;
                echk  = crx;
                edata = (VEC[n].mode[1] && VEC[n].sgl && (|VEC[n].flip[15:0])) ? VEC[n].data : drx;
            end
            @(posedge clk);
            #1;
            check(VREQ[n], outs(), {edata, echk, esyn, VEC[n].sgl, VEC[n].dbl});
            @(negedge clk);
        end

        // R9: new inputs must not appear before the next edge
        mode_i = 2'b00;
        data_i = 16'h0000;
        chk_i  = 6'h00;
        @(posedge clk);
        #1;
        check("R9", outs(), 31'd0);
        @(negedge clk);
        data_i = 16'h00F0;
        mode_i = 2'b00;
        #5;
        check("R9", outs(), 31'd0);
        @(posedge clk);
        #1;
        check("R9", outs(), {16'h00F0, ref_gen(16'h00F0), 6'd0, 1'b0, 1'b0});
        @(negedge clk);

        // R8: unused weight-three syndrome via flip of unused column directly
        mode_i = 2'b11;
        data_i = 16'h0000;
        chk_i  = 6'b111000;
        @(posedge clk);
        #1;
        check("R8", outs(), {16'h0000, 6'b111000, 6'b111000, 1'b0, 1'b1});
        @(negedge clk);

        // R10: mid-run reset with an error present
        mode_i = 2'b10;
        data_i = 16'h0001;
        chk_i  = 6'd0;
        rst    = 1'b1;
        @(posedge clk);
        #1;
        check("R10", outs(), 31'd0);
        @(negedge clk);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule